// File: doc/BRIEF.md
# Serial Slave Port with Self-Detected Clock Polarity

This block is the serial front end of a timekeeping and RAM device. A host selects it with an active-high select line, clocks in an address byte and then one or more data bytes, all MSB first. The top bit of the address byte picks the direction and the remaining bits pick a location. On a write, each complete data byte becomes a one-cycle write strobe towards the register file. On a read, the block fetches a byte from the register file and shifts it out. Consecutive bytes in one selection go to consecutive locations.

The host may idle its serial clock either high or low. The block does not need to be told which one. It samples the clock level at the moment select rises, keeps that level as the idle level until select falls, and derives both active edges from it. The edge that leaves the idle level changes the output bit. The edge that returns to the idle level latches the input bit. All serial inputs are oversampled through synchronisers in the system clock domain. The serial clock half-period must therefore span at least six system clocks.

The output driver is released, and left high-impedance, except while a fetched read byte is ready. A selection that ends without any serial clock edge is not a transfer. Instead it produces a one-cycle watchdog-service pulse.

Top module: `spi_autopol_slave`

## Requirements
- R1: While select is low, the serial clock and data inputs have no effect. No read or write strobe is raised and `misoOe` stays 0. After reset `misoOe`, `regWrEn`, `regRdEn` and `wdogPulse` are all 0.
- R2: The serial clock level seen when select rises is held as the idle level for the whole selection. Both idle-low and idle-high hosts transfer correctly.
- R3: The input bit is latched on the edge that returns the clock to its idle level. The output bit changes on the edge that leaves the idle level, one clock cycle per bit.
- R4: Bytes are 8 bits, MSB first. In the first byte after select rises, bit 7 = 1 means write and bit 7 = 0 means read. Bits 6..0 give the start location.
- R5: In a write, every complete data byte produces exactly one cycle of `regWrEn`, with `regAddr` and `regWrData` holding that byte's location and value. `regWrEn` and `regRdEn` are never high together.
- R6: Each further data byte in a selection goes to the next location. The location is 7 bits wide and wraps from 127 to 0.
- R7: In a read, `regRdEn` fetches the byte at the current location once the address byte is complete. It fetches again after each data byte. `misoOe` stays 0 during the address byte and rises once the first byte is loaded. The host then receives the fetched bytes MSB first.
- R8: `misoOe` stays 0 for the whole of a write selection.
- R9: If select falls before the 8th bit of a data byte, the partial byte is discarded. No write strobe is raised and the location keeps its old content.
- R10: A selection with no serial clock edge gives exactly one cycle of `wdogPulse` after select falls. A selection that carries clock edges gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selIn | input | 1 | Slave select, active high |
| sckIn | input | 1 | Serial clock from host, either idle level |
| mosiIn | input | 1 | Serial data from host |
| misoOut | output | 1 | Serial data to host; high-impedance when not enabled |
| misoOe | output | 1 | Output enable of `misoOut` |
| regWrEn | output | 1 | One-cycle write strobe to the register file |
| regRdEn | output | 1 | One-cycle read fetch strobe to the register file |
| regAddr | output | 7 | Location for the current strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Byte returned for `regAddr`, combinational |
| wdogPulse | output | 1 | One-cycle pulse for a selection without clock edges |

## Verification
Single-byte and burst writes and reads are run with the clock idling low and, separately, idling high. A fault in polarity capture or edge selection then shows as shifted or inverted bytes in one mode only. A burst that starts at location 126 or 127 separates a correct 7-bit wrap from an overflow into the direction bit. A selection dropped four bits into a data byte, and clock toggling with select low, check that incomplete or unselected activity leaves the register file alone. A bare select pulse, compared against the clocked selections before it, tells the watchdog case apart from a real transfer.

// File: rtl/spi_autopol_pkg.sv
package spi_autopol_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // latch one input bit
    logic shiftOut;   // advance output byte by one bit
    logic loadTx;     // load fetched read byte
    logic captureWr;  // capture completed write byte
  } dpCtrl_t;

endpackage

// File: rtl/spi_autopol_sync.sv
module spi_autopol_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/spi_autopol_ctrl.sv
module spi_autopol_ctrl
  import spi_autopol_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LOC_W = DATA_W - 1,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selSync,
  input  logic              sckSync,
  input  logic [DATA_W-1:0] rxNext,
  output dpCtrl_t           dpCtrl,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [LOC_W-1:0]  regAddr,
  output logic              misoOe,
  output logic              wdogPulse
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  xferState_t       state;
  logic             selPrev;
  logic             sckPrev;
  logic             idlePol;
  logic             isWrite;
  logic             sawClock;
  logic             txReady;
  logic [CNT_W-1:0] bitCnt;
  logic [LOC_W-1:0] addrReg;

  logic selRise, selFall, active;
  logic sckChange, returnEdge, leaveEdge, byteDone;

  assign selRise    = selSync && !selPrev;
  assign selFall    = !selSync && selPrev;
  assign active     = (state != ST_IDLE) && selSync;
  assign sckChange  = sckSync ^ sckPrev;
  assign returnEdge = sckChange && (sckSync == idlePol);
  assign leaveEdge  = sckChange && (sckSync != idlePol);
  assign byteDone   = active && returnEdge && (bitCnt == LAST_BIT);

  always_comb begin
    dpCtrl           = '0;
    dpCtrl.shiftIn   = active && returnEdge;
    dpCtrl.shiftOut  = active && leaveEdge && (state == ST_DATA) &&
                       !isWrite && (bitCnt != '0);
    dpCtrl.loadTx    = regRdEn;
    dpCtrl.captureWr = byteDone && (state == ST_DATA) && isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      selPrev   <= 1'b0;
      sckPrev   <= 1'b0;
      idlePol   <= 1'b0;
      isWrite   <= 1'b0;
      sawClock  <= 1'b0;
      txReady   <= 1'b0;
      bitCnt    <= '0;
      addrReg   <= '0;
      regWrEn   <= 1'b0;
      regRdEn   <= 1'b0;
      wdogPulse <= 1'b0;
    end else begin
      selPrev   <= selSync;
      sckPrev   <= sckSync;
      regWrEn   <= 1'b0;
      regRdEn   <= 1'b0;
      wdogPulse <= 1'b0;
      if (regWrEn) addrReg <= addrReg + 1'b1;
      if (regRdEn) txReady <= 1'b1;
      if (selRise) begin
        state    <= ST_ADDR;
        idlePol  <= sckSync;
        bitCnt   <= '0;
        sawClock <= 1'b0;
        txReady  <= 1'b0;
      end else if (selFall) begin
        state     <= ST_IDLE;
        txReady   <= 1'b0;
        wdogPulse <= (state != ST_IDLE) && !sawClock;
      end else if (active) begin
        if (sckChange) sawClock <= 1'b1;
        if (returnEdge) begin
          bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        end
        if (byteDone) begin
          if (state == ST_ADDR) begin
            isWrite <= rxNext[DATA_W-1];
            addrReg <= rxNext[LOC_W-1:0];
            regRdEn <= !rxNext[DATA_W-1];
            state   <= ST_DATA;
          end else if (isWrite) begin
            regWrEn <= 1'b1;
          end else begin
            addrReg <= addrReg + 1'b1;
            regRdEn <= 1'b1;
          end
        end
      end
    end
  end

  assign regAddr = addrReg;
  assign misoOe  = txReady;

  // R1: nothing leaves the block once select has been low for two cycles
  assert_quiet_unselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!selSync && !selPrev) |-> (!regWrEn && !regRdEn && !misoOe));

  // R2: captured idle level is held while selected
  assert_pol_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selSync && selPrev) |=> $stable(idlePol));

  // R5: write and read strobes are exclusive
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R6: a write strobe advances the location by one
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == $past(regAddr) + 1'b1));

  // R8: output never enabled in a write selection
  assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !isWrite);

  // R10: watchdog pulse lasts one cycle
  assert_wdog_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    wdogPulse |=> !wdogPulse);

endmodule

// File: rtl/spi_autopol_dp.sv
module spi_autopol_dp
  import spi_autopol_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              mosiSync,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] rxNext,
  output logic [DATA_W-1:0] regWrData,
  output logic              misoBit
);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;

  assign rxNext  = {rxShift[DATA_W-2:0], mosiSync};
  assign misoBit = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      regWrData <= '0;
    end else begin
      if (dpCtrl.shiftIn)   rxShift   <= rxNext;
      if (dpCtrl.captureWr) regWrData <= rxNext;
      if (dpCtrl.loadTx)
        txShift <= regRdData;
      else if (dpCtrl.shiftOut)
        txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  // R3: output bit moves only on a shift or load strobe
  assert_tx_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.shiftOut && !dpCtrl.loadTx) |=> (misoBit == $past(misoBit)));

  // R4: input bits enter at the LSB and move towards the MSB
  assert_rx_msb_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.shiftIn |=> (rxShift[0] == $past(mosiSync)));

endmodule

// File: rtl/spi_autopol_slave.sv
module spi_autopol_slave
  import spi_autopol_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LOC_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [LOC_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              wdogPulse
);

  logic [2:0]        syncVec;
  logic              selSync, sckSync, mosiSync;
  logic [DATA_W-1:0] rxNext;
  logic              misoBit;
  dpCtrl_t           dpCtrl;

  spi_autopol_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({selIn, sckIn, mosiIn}),
    .syncOut(syncVec)
  );

  assign {selSync, sckSync, mosiSync} = syncVec;

  spi_autopol_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selSync  (selSync),
    .sckSync  (sckSync),
    .rxNext   (rxNext),
    .dpCtrl   (dpCtrl),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .misoOe   (misoOe),
    .wdogPulse(wdogPulse)
  );

  spi_autopol_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .mosiSync (mosiSync),
    .regRdData(regRdData),
    .rxNext   (rxNext),
    .regWrData(regWrData),
    .misoBit  (misoBit)
  );

  assign misoOut = misoOe ? misoBit : 1'bz;

endmodule

// File: tb/spi_autopol_slave_tb.sv
module spi_autopol_slave_tb;

  localparam int H = 8;  // serial half-period in system clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, sel, sck, mosi;
  wire        misoOut;
  logic       misoOe, regWrEn, regRdEn, wdogPulse;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] mem [128];
  int  wrCount = 0, rdCount = 0, wdogCount = 0;
  int  checks = 0, fails = 0;
  bit  inWrite = 0, oeInWrite = 0, pol = 0;

  spi_autopol_slave u_dut (
    .clk(clk), .rstN(rstN), .selIn(sel), .sckIn(sck), .mosiIn(mosi),
    .misoOut(misoOut), .misoOe(misoOe), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .wdogPulse(wdogPulse)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin mem[regAddr] <= regWrData; wrCount <= wrCount + 1; end
    if (regRdEn) rdCount <= rdCount + 1;
    if (wdogPulse) wdogCount <= wdogCount + 1;
    if (inWrite && misoOe) oeInWrite <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beginXfer(input bit p);
    pol = p; sck = p; waitClk(4);
    sel = 1'b1; waitClk(H);
  endtask

  task automatic endXfer();
    waitClk(H); sel = 1'b0; waitClk(10);
    sck = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = ~pol; mosi = tx[i]; waitClk(H);
      rx[i] = misoOut;
      sck = pol; waitClk(H);
    end
  endtask

  task automatic testReset();
    check(misoOe == 1'b0, "R1 reset misoOe", int'(misoOe), 0);
    check(!regWrEn && !regRdEn, "R1 reset strobes", int'({regWrEn, regRdEn}), 0);
    check(wdogPulse == 1'b0, "R1 reset wdogPulse", int'(wdogPulse), 0);
  endtask

  task automatic testWriteSingle();
    logic [7:0] rx;
    int w0 = wrCount;
    inWrite = 1;
    beginXfer(1'b0);
    sendBits(8'h85, 8, rx);
    sendBits(8'hA5, 8, rx);
    endXfer();
    inWrite = 0;
    check(mem[5] == 8'hA5, "R3 R4 single write idle-low", int'(mem[5]), 'hA5);
    check(wrCount - w0 == 1, "R5 one strobe per byte", wrCount - w0, 1);
    check(!oeInWrite, "R8 misoOe in write", int'(oeInWrite), 0);
  endtask

  task automatic testWriteBurst();
    logic [7:0] rx;
    int w0 = wrCount;
    inWrite = 1;
    beginXfer(1'b1);
    sendBits(8'hFE, 8, rx);
    sendBits(8'h11, 8, rx);
    sendBits(8'h22, 8, rx);
    sendBits(8'h33, 8, rx);
    endXfer();
    inWrite = 0;
    check(mem[126] == 8'h11, "R2 burst write idle-high loc126", int'(mem[126]), 'h11);
    check(mem[127] == 8'h22, "R6 burst write loc127", int'(mem[127]), 'h22);
    check(mem[0] == 8'h33, "R6 wrap to loc0", int'(mem[0]), 'h33);
    check(wrCount - w0 == 3, "R5 burst strobe count", wrCount - w0, 3);
    check(!oeInWrite, "R8 misoOe in burst write", int'(oeInWrite), 0);
  endtask

  task automatic testReadSingle();
    logic [7:0] rx;
    mem[16] = 8'h5C;
    beginXfer(1'b0);
    check(misoOe == 1'b0, "R7 oe low before address", int'(misoOe), 0);
    sendBits(8'h10, 8, rx);
    check(misoOe == 1'b1, "R7 oe high after read address", int'(misoOe), 1);
    sendBits(8'h00, 8, rx);
    endXfer();
    check(rx == 8'h5C, "R3 R7 single read idle-low", int'(rx), 'h5C);
    check(misoOe == 1'b0, "R1 oe low after deselect", int'(misoOe), 0);
  endtask

  task automatic testReadBurst();
    logic [7:0] rxA, rxB;
    logic [7:0] rx;
    int r0 = rdCount;
    mem[127] = 8'hC3; mem[0] = 8'h96;
    beginXfer(1'b1);
    sendBits(8'h7F, 8, rx);
    sendBits(8'h00, 8, rxA);
    sendBits(8'h00, 8, rxB);
    endXfer();
    check(rxA == 8'hC3, "R2 R7 burst read idle-high first", int'(rxA), 'hC3);
    check(rxB == 8'h96, "R6 burst read wraps", int'(rxB), 'h96);
    check(rdCount - r0 == 3, "R7 fetch count", rdCount - r0, 3);
  endtask

  task automatic testAbort();
    logic [7:0] rx;
    int w0;
    mem[32] = 8'h44;
    w0 = wrCount;
    beginXfer(1'b0);
    sendBits(8'hA0, 8, rx);
    sendBits(8'hFF, 4, rx);
    endXfer();
    check(wrCount == w0, "R9 no strobe on partial byte", wrCount - w0, 0);
    check(mem[32] == 8'h44, "R9 location unchanged", int'(mem[32]), 'h44);
    beginXfer(1'b0);
    sendBits(8'hA0, 8, rx);
    sendBits(8'h69, 8, rx);
    endXfer();
    check(mem[32] == 8'h69, "R9 recovery write", int'(mem[32]), 'h69);
  endtask

  task automatic testUnselected();
    int w0 = wrCount, r0 = rdCount;
    bit oeSeen = 0;
    for (int i = 0; i < 24; i++) begin
      sck = ~sck; mosi = i[0];
      waitClk(H);
      if (misoOe) oeSeen = 1;
    end
    sck = 1'b0; waitClk(H);
    check(wrCount == w0 && rdCount == r0, "R1 no strobes unselected",
          (wrCount - w0) + (rdCount - r0), 0);
    check(!oeSeen, "R1 oe stays low unselected", int'(oeSeen), 0);
  endtask

  task automatic testWatchdog();
    int d0 = wdogCount;
    check(d0 == 0, "R10 no pulse for clocked selections", d0, 0);
    beginXfer(1'b0);
    endXfer();
    check(wdogCount - d0 == 1, "R10 one pulse bare select", wdogCount - d0, 1);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    waitClk(150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i);
    rstN = 1'b0; sel = 1'b0; sck = 1'b0; mosi = 1'b0;
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testWriteSingle();
    testWriteBurst();
    testReadSingle();
    testReadBurst();
    testAbort();
    testUnselected();
    testWatchdog();
    finishRun();
  end

endmodule